// File: doc/BRIEF.md
# Reset Cause Status Register

This block is an 8-bit status register that tells software why the most recent reset happened and whether the chip has entered stop mode. Four reset request lines feed it: the external reset pin, the halt instruction (software reset), the watchdog and the low-voltage detector. A request on any of them reloads the register on the next clock edge. Two read-only bits hold the cause, and bit 3 returns to 1.

A stop-entry strobe arms a stop flag. The flag becomes visible only at the next instruction-boundary strobe, so the instruction that enters stop mode, even if it reads this register, still sees 0. Software clears the flag with a write. The register port has an address-match select, a write enable and 8-bit write data. Read data is combinational and valid in the same cycle as the select.

An active-low power-on input brings the register to the external-reset image before any request arrives.

Top module: `rst_cause_status`

## Requirements
- R1: While `porN` is low, the register holds 8'h08, which is the external-reset image.
- R2: A reset request loads bits [6:5] with the cause code on the next clock edge. The codes are 2'b00 external, 2'b01 software (halt instruction), 2'b10 watchdog and 2'b11 low-voltage. The register then reads 8'h08, 8'h28, 8'h48 or 8'h68, and that reload overrides any write or stop event in the same cycle.
- R3: When several requests are active in the same cycle, the cause is recorded by priority: low-voltage, then watchdog, then software, then external.
- R4: Bits [6:5] change only on a reset request, and software writes to them are ignored. Bits 4, 2, 1 and 0 always read 0.
- R5: Bit 3 is a read/write bit that takes `wrData[3]` on a write and is set to 1 by every reset request and by `porN`.
- R6: A `stopEntry` pulse arms a pending stop. Bit 7 (the stop flag) is set on the edge that ends the first cycle with `instrEnd` high, at or after the arming. A read in that `instrEnd` cycle returns bit 7 as 0, and reads from the next cycle return 1.
- R7: A write with `wrData[7]`=0 clears the stop flag, and a write with `wrData[7]`=1 leaves it unchanged. If the flag is set and cleared in the same cycle, the set wins.
- R8: `rdData` equals the register image in any cycle with `rdSel` high and is 8'h00 otherwise. A write takes effect only when `rdSel` and `wrEn` are both high.
- R9: A reset request clears both the stop flag and any pending stop, so a later `instrEnd` sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| extRstReq | input | 1 | External pin reset request |
| swHaltReq | input | 1 | Software (halt) reset request |
| wdgRstReq | input | 1 | Watchdog reset request |
| lvdRstReq | input | 1 | Low-voltage reset request |
| stopEntry | input | 1 | Pulse: the current instruction enters stop mode |
| instrEnd | input | 1 | Pulse: the current instruction completes this cycle |
| rdSel | input | 1 | Address match for the register |
| wrEn | input | 1 | Write enable, valid with `rdSel` |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of `rdSel` |

## Verification
The bench goes after the following corner cases:

- **Simultaneous reset requests.** A wrong priority order would report a watchdog reset as low-voltage or as software.
- **Read in the `instrEnd` cycle.** A design that exposes the flag one cycle early would return 1 in the cycle the instruction completes. A design that ignores the pending state would never set the flag when `stopEntry` and `instrEnd` arrive in different cycles.
- **Collisions.** These include a write of 0 to bit 7 in the cycle the flag is set, a reset request during a pending stop, and writes of ones into the cause and reserved bits. Each of these exposes a wrong override order or a leaky write mask.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [1:0] {
    CAUSE_EXT = 2'b00,
    CAUSE_SW  = 2'b01,
    CAUSE_WDG = 2'b10,
    CAUSE_LVD = 2'b11
  } cause_e;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic   loadCause;  // reset request: reload whole image
    cause_e cause;      // cause code to load
    logic   setStop;    // stop flag becomes visible
    logic   clrStop;    // software clears stop flag
    logic   wrCtl;      // software write to the read/write bit
    logic   ctlVal;     // value for that bit
  } ctlStrobes_t;

endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STOP_BIT = 7,
  parameter int CTL_BIT  = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extRstReq,
  input  logic              swHaltReq,
  input  logic              wdgRstReq,
  input  logic              lvdRstReq,
  input  logic              stopEntry,
  input  logic              instrEnd,
  input  logic              rdSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobes_t       strobes
);

  logic   anyReq;
  logic   wrHit;
  logic   stopPending;
  cause_e causeSel;
  logic   unusedWrBits;

  assign anyReq = extRstReq | swHaltReq | wdgRstReq | lvdRstReq;
  assign wrHit  = rdSel & wrEn & ~anyReq;
  assign unusedWrBits = ^wrData;

  // Fixed priority: low-voltage > watchdog > software > external
  always_comb begin
    if (lvdRstReq)      causeSel = CAUSE_LVD;
    else if (wdgRstReq) causeSel = CAUSE_WDG;
    else if (swHaltReq) causeSel = CAUSE_SW;
    else                causeSel = CAUSE_EXT;
  end

  // Stop entry waits here until the instruction completes
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)          stopPending <= 1'b0;
    else if (anyReq)    stopPending <= 1'b0;
    else if (instrEnd)  stopPending <= 1'b0;
    else if (stopEntry) stopPending <= 1'b1;
  end

  always_comb begin
    strobes.loadCause = anyReq;
    strobes.cause     = causeSel;
    strobes.setStop   = ~anyReq & instrEnd & (stopPending | stopEntry);
    strobes.clrStop   = wrHit & ~wrData[STOP_BIT];
    strobes.wrCtl     = wrHit;
    strobes.ctlVal    = wrData[CTL_BIT];
  end

  // R6: an instruction boundary always consumes the pending stop
  assert_pending_consumed_R6: assert property (@(posedge clk) disable iff (!porN)
    instrEnd |=> !stopPending);

  // R9: a reset request drops any pending stop
  assert_reset_drops_pending_R9: assert property (@(posedge clk) disable iff (!porN)
    anyReq |=> !stopPending);

endmodule

// File: rtl/rcs_dp.sv
module rcs_dp
  import rcs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STOP_BIT  = 7,
  parameter int CAUSE_LSB = 5,
  parameter int CTL_BIT   = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  ctlStrobes_t       strobes,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData
);

  localparam int CAUSE_W = 2;

  logic              stopFlag;
  cause_e            causeBits;
  logic              ctlBit;
  logic [DATA_W-1:0] regImage;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stopFlag  <= 1'b0;
      causeBits <= CAUSE_EXT;
      ctlBit    <= 1'b1;
    end else if (strobes.loadCause) begin
      stopFlag  <= 1'b0;
      causeBits <= strobes.cause;
      ctlBit    <= 1'b1;
    end else begin
      if (strobes.setStop)      stopFlag <= 1'b1;
      else if (strobes.clrStop) stopFlag <= 1'b0;
      if (strobes.wrCtl)        ctlBit   <= strobes.ctlVal;
    end
  end

  // Assemble the image; reserved positions read zero
  always_comb begin
    regImage = '0;
    regImage[STOP_BIT] = stopFlag;
    regImage[CAUSE_LSB +: CAUSE_W] = causeBits;
    regImage[CTL_BIT] = ctlBit;
  end

  assign rdData = rdSel ? regImage : '0;

  // R2: a reset request loads the selected cause code
  assert_cause_loaded_R2: assert property (@(posedge clk) disable iff (!porN)
    strobes.loadCause |=> causeBits == $past(strobes.cause));

  // R4: the cause bits are read-only between reset requests
  assert_cause_readonly_R4: assert property (@(posedge clk) disable iff (!porN)
    !strobes.loadCause |=> $stable(causeBits));

  // R5: the read/write bit comes out of a reset request as 1
  assert_ctl_after_load_R5: assert property (@(posedge clk) disable iff (!porN)
    strobes.loadCause |=> ctlBit);

  // R6: the stop flag only rises on a set strobe
  assert_stop_rise_R6: assert property (@(posedge clk) disable iff (!porN)
    $rose(stopFlag) |-> $past(strobes.setStop));

  // R7: a set wins over a same-cycle clear
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!porN)
    strobes.setStop |=> stopFlag);

endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rcs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STOP_BIT  = 7,
  parameter int CAUSE_LSB = 5,
  parameter int CTL_BIT   = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extRstReq,
  input  logic              swHaltReq,
  input  logic              wdgRstReq,
  input  logic              lvdRstReq,
  input  logic              stopEntry,
  input  logic              instrEnd,
  input  logic              rdSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  ctlStrobes_t strobes;

  rcs_ctrl #(
    .DATA_W(DATA_W), .STOP_BIT(STOP_BIT), .CTL_BIT(CTL_BIT)
  ) i_ctrl (
    .clk(clk), .porN(porN),
    .extRstReq(extRstReq), .swHaltReq(swHaltReq),
    .wdgRstReq(wdgRstReq), .lvdRstReq(lvdRstReq),
    .stopEntry(stopEntry), .instrEnd(instrEnd),
    .rdSel(rdSel), .wrEn(wrEn), .wrData(wrData),
    .strobes(strobes)
  );

  rcs_dp #(
    .DATA_W(DATA_W), .STOP_BIT(STOP_BIT), .CAUSE_LSB(CAUSE_LSB), .CTL_BIT(CTL_BIT)
  ) i_dp (
    .clk(clk), .porN(porN), .strobes(strobes),
    .rdSel(rdSel), .rdData(rdData)
  );

  // R8: an unselected port reads zero
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!porN)
    !rdSel |-> rdData == '0);

endmodule

// File: tb/test_rst_cause_status.sv
`timescale 1ns/1ps
module test_rst_cause_status;

  logic       clk = 1'b0;
  logic       porN;
  logic       extRstReq, swHaltReq, wdgRstReq, lvdRstReq;
  logic       stopEntry, instrEnd, rdSel, wrEn;
  logic [7:0] wrData;
  logic [7:0] rdData;

  int passCount = 0;
  int failCount = 0;
  logic [7:0] expVal;
  logic       expPend;

  always #2.5 clk = ~clk;

  rst_cause_status i_rst_cause_status (
    .clk(clk), .porN(porN),
    .extRstReq(extRstReq), .swHaltReq(swHaltReq),
    .wdgRstReq(wdgRstReq), .lvdRstReq(lvdRstReq),
    .stopEntry(stopEntry), .instrEnd(instrEnd),
    .rdSel(rdSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData)
  );

  // Expected next {pending, image}, from the requirements
  function automatic logic [8:0] modelNext(logic [7:0] v, logic p);
    logic [7:0] n;
    logic       np;
    logic [1:0] code;
    n = v;
    np = p;
    if (lvdRstReq | wdgRstReq | swHaltReq | extRstReq) begin
      code = lvdRstReq ? 2'b11 : wdgRstReq ? 2'b10 : swHaltReq ? 2'b01 : 2'b00;
      n = {1'b0, code, 5'b01000};
      np = 1'b0;
    end else begin
      if (rdSel && wrEn) begin
        n[3] = wrData[3];
        if (!wrData[7]) n[7] = 1'b0;
      end
      if (instrEnd && (p || stopEntry)) n[7] = 1'b1;
      np = instrEnd ? 1'b0 : (p | stopEntry);
    end
    return {np, n};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    if (act === exp) passCount++;
    else begin
      failCount++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {extRstReq, swHaltReq, wdgRstReq, lvdRstReq} = '0;
    {stopEntry, instrEnd, rdSel, wrEn} = '0;
    wrData = '0;
  endtask

  // Inputs already set at a falling edge: check read, clock, update model
  task automatic step(string tag);
    logic [8:0] nx;
    #1;
    check(tag, rdData, rdSel ? expVal : 8'h00);
    nx = modelNext(expVal, expPend);
    @(posedge clk);
    {expPend, expVal} = nx;
    @(negedge clk);
  endtask

  task automatic readCheck(string tag);
    idle(); rdSel = 1'b1; step(tag);
  endtask

  task automatic resetReq(logic e, logic s, logic w, logic l);
    idle();
    {extRstReq, swHaltReq, wdgRstReq, lvdRstReq} = {e, s, w, l};
    step("R2");
  endtask

  initial begin
    #1000000;
    failCount++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", passCount, passCount + failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    porN = 1'b0;
    expVal = 8'h08; expPend = 1'b0;
    rdSel = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R1 por image", rdData, 8'h08);
    porN = 1'b1;
    @(negedge clk);
    readCheck("R1");

    // R2: each cause alone
    resetReq(1, 0, 0, 0); readCheck("R2 ext");
    check("R2 ext value", expVal, 8'h08);
    resetReq(0, 1, 0, 0); readCheck("R2 sw");
    resetReq(0, 0, 1, 0); readCheck("R2 wdg");
    resetReq(0, 0, 0, 1); readCheck("R2 lvd");
    check("R2 lvd value", expVal, 8'h68);

    // R3: simultaneous requests
    resetReq(1, 1, 1, 1); readCheck("R3 all");
    check("R3 all value", expVal, 8'h68);
    resetReq(1, 1, 1, 0); readCheck("R3 wdg wins");
    resetReq(1, 1, 0, 0); readCheck("R3 sw wins");

    // R4/R5: write ones everywhere, then zeros
    idle(); rdSel = 1; wrEn = 1; wrData = 8'hFF; step("R4 write ones");
    readCheck("R4 cause unchanged");
    idle(); rdSel = 1; wrEn = 1; wrData = 8'h00; step("R5 clear bit3");
    readCheck("R5 bit3 zero");
    check("R5 model", expVal, 8'h20);
    // R8: write without select is ignored
    idle(); wrEn = 1; wrData = 8'h08; step("R8 no select");
    readCheck("R8 unchanged");

    // R6: stop entry then later instruction end
    idle(); rdSel = 1; stopEntry = 1; step("R6 entry cycle");
    readCheck("R6 still armed");
    idle(); rdSel = 1; instrEnd = 1; step("R6 same-instruction read");
    readCheck("R6 next read");
    check("R6 flag set", expVal[7], 1'b1);
    // R7: write 1 keeps, write 0 clears
    idle(); rdSel = 1; wrEn = 1; wrData = 8'h80; step("R7 write one");
    readCheck("R7 kept");
    idle(); rdSel = 1; wrEn = 1; wrData = 8'h00; step("R7 write zero");
    readCheck("R7 cleared");
    // R7: set and clear collide
    idle(); rdSel = 1; wrEn = 1; wrData = 8'h00; stopEntry = 1; instrEnd = 1;
    step("R7 collision");
    readCheck("R7 set wins");
    // R9: reset request during pending stop
    idle(); stopEntry = 1; step("R9 arm");
    resetReq(0, 0, 1, 0);
    idle(); rdSel = 1; instrEnd = 1; step("R9 end after reset");
    readCheck("R9 no flag");
    check("R9 model", expVal, 8'h48);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      extRstReq = ($urandom % 80) == 0;
      swHaltReq = ($urandom % 80) == 0;
      wdgRstReq = ($urandom % 80) == 0;
      lvdRstReq = ($urandom % 100) == 0;
      stopEntry = ($urandom % 8) == 0;
      instrEnd  = ($urandom % 3) == 0;
      rdSel     = ($urandom % 2) == 0;
      wrEn      = ($urandom % 3) == 0;
      wrData    = 8'($urandom);
      step("R8 random");
    end

    $display("%0d/%0d checks passed", passCount, passCount + failCount);
    $finish;
  end

endmodule